// File: doc/BRIEF.md
# Flash Rewrite Command Gatekeeper

This block stands between the command port of a processor and a behavioural flash array. Software issues one command per cycle with an opcode and an address. The gatekeeper judges each command against the active erase-write mode, the target block and lock information, and then does one of three things. It starts an automatic program or erase in the array, it switches the read mode, or it rejects the command and records a sticky command error.

Two erase-write modes exist, chosen by a mode input. In the first mode (EW0) the rewrite routine runs from memory outside the flash, so few restrictions apply, and status is read back after each operation. In the second mode (EW1) the rewrite routine runs from the flash itself. For that reason the block that holds the routine is protected, the processor is held for the whole operation, and the array view returns as soon as the operation ends. The index of the routine's block sits in a register that software writes. The mode is captured when a program or erase is accepted, so a later change of the mode input does not alter how the running operation finishes.

Top module: `flash_gate_top`

## Requirements
- R1: After reset, ready is 1, readMode is 0 (array view), progErr, eraseErr, cmdErr, cpuHold and arrayStart are 0, statusWord is 8'h80, and the rewrite-block register holds 0.
- R2: Opcode 0 is read-array and sets readMode to 0. Opcode 1 is read-status and, with modeEw1=0, sets readMode to 1. Neither starts an array operation.
- R3: The target block is the top BLK_W bits of cmdAddr. Blocks at or above USER_BLOCKS (6 and 7 by default) are boot blocks. Program (opcode 2) and block erase (opcode 3) aimed at a boot block are rejected in both modes.
- R4: With modeEw1=1, program or block erase aimed at the block held in the rewrite-block register (written by rwBlkWe/rwBlkIdx) is rejected. With modeEw1=0 the same command is accepted.
- R5: With modeEw1=1, erase-all-unlocked (opcode 4) is rejected when lockBits[rewrite block] is 1 (unlocked) or when lockDisable is 1. Otherwise it is accepted.
- R6: With modeEw1=1, read-status (opcode 1) is rejected.
- R7: A rejected command, which includes opcodes 5 to 7, sets cmdErr. cmdErr stays set until reset. A rejected command starts no array operation and leaves readMode unchanged.
- R8: An accepted program or erase drives arrayStart high for exactly the one cycle after acceptance. In that cycle arrayOp and arrayAddr carry the command. ready is 0 from that cycle until the edge that samples arrayDone, and is 1 in the cycle after that edge.
- R9: cpuHold is 1 throughout an operation that was accepted with modeEw1=1, and it falls together with the return of ready. It stays 0 throughout an operation accepted with modeEw1=0.
- R10: On completion, readMode becomes 1 if the operation was accepted with modeEw1=0, and 0 if it was accepted with modeEw1=1, whatever modeEw1 is at completion.
- R11: arrayErr sampled with arrayDone sets progErr for a program, or sets eraseErr for a block erase or erase-all. Both flags stay set until reset.
- R12: Commands that arrive while busy are ignored, including one in the same cycle as arrayDone. Such a command starts nothing, leaves cmdErr as it was, and leaves readMode as it was until completion.
- R13: statusWord bit 7 is ready, bit 5 is eraseErr, bit 4 is progErr, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeEw1 | input | 1 | 0 selects EW0, 1 selects EW1 |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 3 | Command opcode |
| cmdAddr | input | ADDR_W | Command address; top BLK_W bits give the block |
| rwBlkWe | input | 1 | Write strobe for the rewrite-block register |
| rwBlkIdx | input | BLK_W | New rewrite-block index |
| lockBits | input | 2**BLK_W | Per-block lock bit, 1 means unlocked |
| lockDisable | input | 1 | Global lock-disable control |
| arrayStart | output | 1 | One-cycle start pulse to the array |
| arrayOp | output | 3 | Opcode of the started operation |
| arrayAddr | output | ADDR_W | Address of the started operation |
| arrayDone | input | 1 | Array completion pulse |
| arrayErr | input | 1 | Array failure, valid with arrayDone |
| cpuHold | output | 1 | Processor hold request |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| readMode | output | 1 | 0 array view, 1 status view |
| progErr | output | 1 | Sticky program failure |
| eraseErr | output | 1 | Sticky erase failure |
| cmdErr | output | 1 | Sticky rejected-command flag |
| statusWord | output | 8 | Status byte for the status view |

## Verification
Completion and a new command can meet in one cycle: arrayDone samples high on the same edge that also sees cmdValid. The bench provokes this on purpose, and also at random at the end of many operations. It then expects no start pulse, ready back to 1, the completion read mode rather than the one the command asked for, and cmdErr unchanged. The bench also changes modeEw1 at random while an operation runs. This shows that the hold request and the read mode after completion both follow the mode captured when the command was accepted.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [2:0] {
    OP_RD_ARRAY  = 3'd0,
    OP_RD_STATUS = 3'd1,
    OP_PROGRAM   = 3'd2,
    OP_BLK_ERASE = 3'd3,
    OP_ERASE_ALL = 3'd4
  } gateOpE;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } gateStateE;

  // strobes from control to datapath, at most one of start/reject/toArray/toStatus
  typedef struct packed {
    logic start;
    logic reject;
    logic toArray;
    logic toStatus;
    logic finish;
  } gateStrobeT;

endpackage

// File: rtl/flash_gate_dp.sv
module flash_gate_dp
  import flash_gate_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BLK_W       = 3,
  parameter int USER_BLOCKS = 6,
  localparam int NUM_BLK    = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStrobeT         stb,
  input  logic               busy,
  input  logic [2:0]         cmdOp,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic               modeEw1,
  input  logic               rwBlkWe,
  input  logic [BLK_W-1:0]   rwBlkIdx,
  input  logic [NUM_BLK-1:0] lockBits,
  input  logic               arrayErr,
  output logic               tgtBoot,
  output logic               tgtRw,
  output logic               rwUnlocked,
  output logic [2:0]         arrayOp,
  output logic [ADDR_W-1:0]  arrayAddr,
  output logic               readMode,
  output logic               progErr,
  output logic               eraseErr,
  output logic               cmdErr,
  output logic [7:0]         statusWord
);

  localparam int ST_READY_BIT = 7;
  localparam int ST_ERASE_BIT = 5;
  localparam int ST_PROG_BIT  = 4;

  logic [BLK_W-1:0]  rwBlkQ;
  logic [BLK_W-1:0]  tgtBlk;
  logic [2:0]        opQ;
  logic [ADDR_W-1:0] addrQ;
  logic              modeHeldQ;
  logic              readModeQ;
  logic              progErrQ;
  logic              eraseErrQ;
  logic              cmdErrQ;
  logic [NUM_BLK-1:0] blkHit;

  assign tgtBlk = cmdAddr[ADDR_W-1 -: BLK_W];
  assign tgtBoot = (32'(tgtBlk) >= 32'(USER_BLOCKS));
  assign tgtRw   = (tgtBlk == rwBlkQ);

  // one-hot select of the rewrite block's lock bit
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_lockSel
    assign blkHit[b] = (rwBlkQ == BLK_W'(b)) && lockBits[b];
  end
  assign rwUnlocked = |blkHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rwBlkQ <= '0;
    end else if (rwBlkWe) begin
      rwBlkQ <= rwBlkIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ       <= '0;
      addrQ     <= '0;
      modeHeldQ <= 1'b0;
    end else if (stb.start) begin
      opQ       <= cmdOp;
      addrQ     <= cmdAddr;
      modeHeldQ <= modeEw1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readModeQ <= 1'b0;
    end else if (stb.finish) begin
      readModeQ <= !modeHeldQ;
    end else if (stb.toArray) begin
      readModeQ <= 1'b0;
    end else if (stb.toStatus) begin
      readModeQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progErrQ  <= 1'b0;
      eraseErrQ <= 1'b0;
      cmdErrQ   <= 1'b0;
    end else begin
      if (stb.reject) cmdErrQ <= 1'b1;
      if (stb.finish && arrayErr) begin
        if (opQ == OP_PROGRAM) progErrQ  <= 1'b1;
        else                   eraseErrQ <= 1'b1;
      end
    end
  end

  always_comb begin
    statusWord               = '0;
    statusWord[ST_READY_BIT] = !busy;
    statusWord[ST_ERASE_BIT] = eraseErrQ;
    statusWord[ST_PROG_BIT]  = progErrQ;
  end

  assign arrayOp   = opQ;
  assign arrayAddr = addrQ;
  assign readMode  = readModeQ;
  assign progErr   = progErrQ;
  assign eraseErr  = eraseErrQ;
  assign cmdErr    = cmdErrQ;

endmodule

// File: rtl/flash_gate_ctrl.sv
module flash_gate_ctrl
  import flash_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeEw1,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       tgtBoot,
  input  logic       tgtRw,
  input  logic       rwUnlocked,
  input  logic       lockDisable,
  input  logic       arrayDone,
  output gateStrobeT stb,
  output logic       busy,
  output logic       arrayStart,
  output logic       cpuHold
);

  gateStateE stateQ;
  gateOpE    op;
  logic      opIsArray;
  logic      legal;
  logic      startQ;
  logic      holdQ;

  assign op = gateOpE'(cmdOp);

  always_comb begin
    opIsArray = 1'b0;
    legal     = 1'b0;
    case (op)
      OP_RD_ARRAY:  legal = 1'b1;
      OP_RD_STATUS: legal = !modeEw1;
      OP_PROGRAM, OP_BLK_ERASE: begin
        opIsArray = 1'b1;
        legal     = !tgtBoot && !(modeEw1 && tgtRw);
      end
      OP_ERASE_ALL: begin
        opIsArray = 1'b1;
        legal     = !(modeEw1 && (rwUnlocked || lockDisable));
      end
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    stb = '0;
    if (stateQ == ST_IDLE && cmdValid) begin
      if (!legal)                 stb.reject   = 1'b1;
      else if (opIsArray)         stb.start    = 1'b1;
      else if (op == OP_RD_ARRAY) stb.toArray  = 1'b1;
      else                        stb.toStatus = 1'b1;
    end
    if (stateQ == ST_BUSY && arrayDone) stb.finish = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      startQ <= 1'b0;
      holdQ  <= 1'b0;
    end else begin
      startQ <= stb.start;
      if (stb.start) begin
        stateQ <= ST_BUSY;
        holdQ  <= modeEw1;
      end else if (stb.finish) begin
        stateQ <= ST_IDLE;
        holdQ  <= 1'b0;
      end
    end
  end

  assign busy       = (stateQ == ST_BUSY);
  assign arrayStart = startQ;
  assign cpuHold    = holdQ;

endmodule

// File: rtl/flash_gate_top.sv
module flash_gate_top
  import flash_gate_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BLK_W       = 3,
  parameter int USER_BLOCKS = 6,
  localparam int NUM_BLK    = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeEw1,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic               rwBlkWe,
  input  logic [BLK_W-1:0]   rwBlkIdx,
  input  logic [NUM_BLK-1:0] lockBits,
  input  logic               lockDisable,
  output logic               arrayStart,
  output logic [2:0]         arrayOp,
  output logic [ADDR_W-1:0]  arrayAddr,
  input  logic               arrayDone,
  input  logic               arrayErr,
  output logic               cpuHold,
  output logic               ready,
  output logic               readMode,
  output logic               progErr,
  output logic               eraseErr,
  output logic               cmdErr,
  output logic [7:0]         statusWord
);

  gateStrobeT stb;
  logic       busy;
  logic       tgtBoot;
  logic       tgtRw;
  logic       rwUnlocked;

  flash_gate_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeEw1    (modeEw1),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .tgtBoot    (tgtBoot),
    .tgtRw      (tgtRw),
    .rwUnlocked (rwUnlocked),
    .lockDisable(lockDisable),
    .arrayDone  (arrayDone),
    .stb        (stb),
    .busy       (busy),
    .arrayStart (arrayStart),
    .cpuHold    (cpuHold)
  );

  flash_gate_dp #(
    .ADDR_W     (ADDR_W),
    .BLK_W      (BLK_W),
    .USER_BLOCKS(USER_BLOCKS)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busy       (busy),
    .cmdOp      (cmdOp),
    .cmdAddr    (cmdAddr),
    .modeEw1    (modeEw1),
    .rwBlkWe    (rwBlkWe),
    .rwBlkIdx   (rwBlkIdx),
    .lockBits   (lockBits),
    .arrayErr   (arrayErr),
    .tgtBoot    (tgtBoot),
    .tgtRw      (tgtRw),
    .rwUnlocked (rwUnlocked),
    .arrayOp    (arrayOp),
    .arrayAddr  (arrayAddr),
    .readMode   (readMode),
    .progErr    (progErr),
    .eraseErr   (eraseErr),
    .cmdErr     (cmdErr),
    .statusWord (statusWord)
  );

  assign ready = !busy;

endmodule

// File: rtl/flash_gate_chk.sv
module flash_gate_chk #(
  parameter int ADDR_W      = 12,
  parameter int BLK_W       = 3,
  parameter int USER_BLOCKS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeEw1,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              arrayStart,
  input logic              arrayDone,
  input logic              cpuHold,
  input logic              ready,
  input logic              readMode,
  input logic              cmdErr
);

  logic bootTgt;
  assign bootTgt = (32'(cmdAddr[ADDR_W-1 -: BLK_W]) >= 32'(USER_BLOCKS));

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    arrayStart |=> !arrayStart);

  assert_busy_at_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    arrayStart |-> !ready);

  assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rstN)
    (arrayDone && !ready) |=> ready);

  assert_hold_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuHold |-> !ready);

  assert_hold_follows_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    arrayStart |-> (cpuHold == $past(modeEw1)));

  assert_boot_reject_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ready && cmdValid && (cmdOp == 3'd2 || cmdOp == 3'd3) && bootTgt)
      |=> (!arrayStart && cmdErr));

  assert_no_status_ew1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && cmdValid && modeEw1 && cmdOp == 3'd1) |=> (cmdErr && $stable(readMode)));

  assert_cmd_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr);

  assert_mode_frozen_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> $stable(readMode));

endmodule

bind flash_gate_top flash_gate_chk #(
  .ADDR_W     (ADDR_W),
  .BLK_W      (BLK_W),
  .USER_BLOCKS(USER_BLOCKS)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeEw1   (modeEw1),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .cmdAddr   (cmdAddr),
  .arrayStart(arrayStart),
  .arrayDone (arrayDone),
  .cpuHold   (cpuHold),
  .ready     (ready),
  .readMode  (readMode),
  .cmdErr    (cmdErr)
);

// File: tb/test_flash_gate_top.sv
module test_flash_gate_top;

  localparam int ADDR_W  = 12;
  localparam int BLK_W   = 3;
  localparam int USER_BL = 6;
  localparam int NB      = 1 << BLK_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeEw1 = 1'b0;
  logic              cmdValid = 1'b0;
  logic [2:0]        cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic              rwBlkWe = 1'b0;
  logic [BLK_W-1:0]  rwBlkIdx = '0;
  logic [NB-1:0]     lockBits = '0;
  logic              lockDisable = 1'b0;
  logic              arrayDone = 1'b0;
  logic              arrayErr = 1'b0;
  logic              arrayStart;
  logic [2:0]        arrayOp;
  logic [ADDR_W-1:0] arrayAddr;
  logic              cpuHold, ready, readMode, progErr, eraseErr, cmdErr;
  logic [7:0]        statusWord;

  always #4 clk = ~clk;

  flash_gate_top i_flash_gate_top (
    .clk(clk), .rstN(rstN), .modeEw1(modeEw1), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .rwBlkWe(rwBlkWe), .rwBlkIdx(rwBlkIdx),
    .lockBits(lockBits), .lockDisable(lockDisable), .arrayStart(arrayStart),
    .arrayOp(arrayOp), .arrayAddr(arrayAddr), .arrayDone(arrayDone),
    .arrayErr(arrayErr), .cpuHold(cpuHold), .ready(ready), .readMode(readMode),
    .progErr(progErr), .eraseErr(eraseErr), .cmdErr(cmdErr), .statusWord(statusWord)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // reference state
  bit  expRm, expCmdErr, expPe, expEe;
  int  expRw;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit legalF(int op, bit m, logic [ADDR_W-1:0] a, int rw,
                                logic [NB-1:0] lb, bit ld);
    int blk;
    blk = int'(a[ADDR_W-1 -: BLK_W]);
    case (op)
      0: return 1'b1;
      1: return !m;
      2, 3: return (blk < USER_BL) && !(m && blk == rw);
      4: return !(m && (lb[rw] || ld));
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] statusF(bit rdy, bit ee, bit pe);
    return {rdy, 1'b0, ee, pe, 4'b0000};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmdValid = 1'b0; rwBlkWe = 1'b0; arrayDone = 1'b0; arrayErr = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expRm = 0; expCmdErr = 0; expPe = 0; expEe = 0; expRw = 0;
    @(negedge clk);
    chk("R1 ready", ready, 1);
    chk("R1 readMode", readMode, 0);
    chk("R1 errs", {progErr, eraseErr, cmdErr}, 0);
    chk("R1 hold/start", {cpuHold, arrayStart}, 0);
    chk("R1 statusWord", statusWord, 8'h80);
  endtask

  task automatic setRw(int idx);
    rwBlkWe = 1'b1; rwBlkIdx = BLK_W'(idx);
    @(negedge clk);
    rwBlkWe = 1'b0;
    expRw = idx;
  endtask

  // issue one command while idle; if it starts an operation, run it to completion
  task automatic issue(string tag, int op, logic [ADDR_W-1:0] a, bit m,
                       int dly, bit err, bit junk, bit same);
    bit acc, isArr;
    acc   = legalF(op, m, a, expRw, lockBits, lockDisable);
    isArr = (op >= 2 && op <= 4);
    modeEw1 = m; cmdValid = 1'b1; cmdOp = 3'(op); cmdAddr = a;
    @(negedge clk);
    cmdValid = 1'b0;
    if (!acc) expCmdErr = 1;
    else if (op == 0) expRm = 0;
    else if (op == 1) expRm = 1;
    chk({tag, " start"}, arrayStart, acc && isArr);
    chk({tag, " cmdErr R7"}, cmdErr, expCmdErr);
    chk({tag, " readMode R2"}, readMode, expRm);
    if (acc && isArr) begin
      chk("R8 ready low", ready, 0);
      chk("R8 arrayOp", arrayOp, op);
      chk("R8 arrayAddr", arrayAddr, a);
      chk("R9 hold at start", cpuHold, m);
      chk("R13 busy status", statusWord, statusF(0, expEe, expPe));
      for (int i = 0; i < dly; i++) begin
        modeEw1 = 1'($urandom_range(0, 1));
        if (junk && $urandom_range(0, 1) == 1) begin
          cmdValid = 1'b1; cmdOp = 3'($urandom_range(0, 7)); cmdAddr = ADDR_W'($urandom);
        end
        @(negedge clk);
        cmdValid = 1'b0;
        chk("R12 no start busy", arrayStart, 0);
        chk("R12 cmdErr busy", cmdErr, expCmdErr);
        chk("R12 readMode busy", readMode, expRm);
        chk("R8 still busy", ready, 0);
        chk("R9 hold busy", cpuHold, m);
      end
      arrayDone = 1'b1; arrayErr = err;
      modeEw1 = 1'($urandom_range(0, 1));
      if (same) begin
        cmdValid = 1'b1; cmdOp = 3'($urandom_range(0, 7)); cmdAddr = ADDR_W'($urandom);
      end
      @(negedge clk);
      arrayDone = 1'b0; arrayErr = 1'b0; cmdValid = 1'b0;
      expRm = !m;
      if (err) begin
        if (op == 2) expPe = 1; else expEe = 1;
      end
      chk("R8 ready back", ready, 1);
      chk("R9 hold released", cpuHold, 0);
      chk("R10 readMode after", readMode, expRm);
      chk("R11 progErr", progErr, expPe);
      chk("R11 eraseErr", eraseErr, expEe);
      chk("R12 done-cycle no start", arrayStart, 0);
      chk("R12 done-cycle cmdErr", cmdErr, expCmdErr);
      chk("R13 status", statusWord, statusF(1, expEe, expPe));
    end
  endtask

  function automatic logic [ADDR_W-1:0] addrOf(int blk);
    return {BLK_W'(blk), (ADDR_W-BLK_W)'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    doReset();
    // R2 read-mode commands
    issue("R2 rdstat", 1, addrOf(0), 0, 0, 0, 0, 0);
    issue("R2 rdarr", 0, addrOf(0), 0, 0, 0, 0, 0);
    // R3 boot blocks
    issue("R3 boot prog ew0", 2, addrOf(7), 0, 0, 0, 0, 0);
    issue("R3 boot erase ew1", 3, addrOf(6), 1, 0, 0, 0, 0);
    doReset();
    // R4 rewrite block
    setRw(2);
    issue("R4 ew1 rw block", 2, addrOf(2), 1, 0, 0, 0, 0);
    doReset();
    setRw(2);
    issue("R4 ew0 rw block", 2, addrOf(2), 0, 2, 0, 0, 0);
    chk("R10 ew0 status view", readMode, 1);
    // R5 erase-all conditions
    doReset();
    setRw(3);
    lockBits = 8'h08; lockDisable = 1'b0;
    issue("R5 unlocked", 4, addrOf(0), 1, 0, 0, 0, 0);
    chk("R5 reject unlocked", cmdErr, 1);
    doReset();
    setRw(3);
    lockBits = 8'hF7; lockDisable = 1'b1;
    issue("R5 lockdis", 4, addrOf(0), 1, 0, 0, 0, 0);
    chk("R5 reject lockdis", cmdErr, 1);
    doReset();
    setRw(3);
    lockBits = 8'hF7; lockDisable = 1'b0;
    issue("R5 ok", 4, addrOf(0), 1, 3, 1, 0, 0);
    chk("R10 ew1 array view", readMode, 0);
    // R6 read status in EW1
    doReset();
    issue("R6 rdstat ew1", 1, addrOf(0), 1, 0, 0, 0, 0);
    chk("R6 reject", cmdErr, 1);
    // R7 invalid opcode, readMode unchanged
    doReset();
    issue("R7 setstat", 1, addrOf(0), 0, 0, 0, 0, 0);
    issue("R7 bad op", 6, addrOf(0), 0, 0, 0, 0, 0);
    chk("R7 readMode kept", readMode, 1);
    // R11 errors
    doReset();
    issue("R11 prog", 2, addrOf(1), 0, 1, 1, 0, 0);
    issue("R11 erase", 3, addrOf(4), 1, 1, 1, 0, 0);
    // R12 command in the completion cycle and during busy
    doReset();
    issue("R12 same", 3, addrOf(5), 0, 2, 0, 1, 1);
    issue("R12 same ew1", 2, addrOf(1), 1, 1, 0, 1, 1);
    // constrained random
    doReset();
    for (int it = 0; it < 400; it++) begin
      if (it % 60 == 59) doReset();
      if ($urandom_range(0, 9) == 0) setRw(int'($urandom_range(0, NB-1)));
      lockBits    = NB'($urandom);
      lockDisable = ($urandom_range(0, 4) == 0);
      issue("rand", int'($urandom_range(0, 7)), ADDR_W'($urandom),
            1'($urandom_range(0, 1)), int'($urandom_range(1, 4)),
            ($urandom_range(0, 3) == 0), 1'b1, 1'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule